// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit sits between a 32-bit processor core and a data memory that is addressed in bytes but organised as 32-bit words. Every access reads or writes one whole word. For a store, the unit turns the byte address, access size and store data into a word address, a set of per-lane write strobes and a lane-replicated write word. For a load, it issues a word read and, one cycle later, takes the addressed byte or halfword out of the returned word and sign- or zero-extends it to 32 bits.

Accesses that are not aligned to their own size are refused. Halfwords need an even address and words need an address that is a multiple of four. A refused access raises `fault` in the request cycle, writes nothing, reads nothing and, for a load, returns zero. A per-request input selects byte numbering. In little-endian numbering, byte offset 0 is the least significant byte of the word. In big-endian numbering, it is the most significant byte. The selection is held with each load so that its response uses the numbering it was issued under.

The response side is a small state machine. `ST_IDLE` means that no load response is due. `ST_LOAD_RESP` means that an accepted read is returning data this cycle. `ST_FAULT_RESP` means that a refused load is answered with zero this cycle. Every state moves on every clock, as follows:
- An accepted load request leads to `ST_LOAD_RESP`.
- A refused load request leads to `ST_FAULT_RESP`.
- A store or an idle cycle leads to `ST_IDLE`.

Reset puts the machine in `ST_IDLE`.

Top module: `lsu_align_unit`

## Requirements
- R1: For every valid request, `mem_word_addr` equals `req_addr[31:2]` in the same cycle.
- R2: A byte store (`req_size` = 2'b00) drives exactly one strobe in the same cycle. Lane k is `mem_wdata[8k+7:8k]`. The strobed lane is k = offset when `big_endian`=0 and k = 3 − offset when `big_endian`=1, where offset = `req_addr[1:0]`. `mem_wdata` is the low store byte repeated in all four lanes.
- R3: A halfword store (`req_size` = 2'b01) drives two strobes. With `big_endian`=0, offset 0 gives 4'b0011 and offset 2 gives 4'b1100. With `big_endian`=1, these are reversed. `mem_wdata` is the low 16 store bits repeated twice.
- R4: A word store (`req_size` = 2'b10) drives strobes 4'b1111, and the store data passes to `mem_wdata` unchanged.
- R5: `fault` rises in the request cycle in these cases:
  - a halfword with `req_addr[0]`=1;
  - a word with `req_addr[1:0]` ≠ 0;
  - any access with `req_size` = 2'b11.

  Byte accesses never fault. While `fault` is high, `mem_be` is 0 and `mem_we` and `mem_re` are low.
- R6: An accepted load raises `mem_re`. In the next cycle, `load_valid` is high and `load_data` holds the selected byte or halfword. Unsigned loads (`req_signed`=0) fill the upper bits with zeros.
- R7: A signed byte load copies bit 7 of the selected byte into `load_data[31:8]`. The byte is selected with the same lane rule as R2.
- R8: A halfword load takes `mem_rdata[15:0]` for offset 0 in little-endian and for offset 2 in big-endian, and `mem_rdata[31:16]` otherwise. A signed halfword load copies bit 15 into bits 31:16.
- R9: A word load returns `mem_rdata` unchanged, in either numbering.
- R10: A refused load produces `load_valid` high with `load_data` = 0 in the next cycle.
- R11: After reset, and in the cycle after a store or an idle cycle, `load_valid` is low and `load_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved (faults) |
| req_signed | input | 1 | Sign-extend a sub-word load |
| big_endian | input | 1 | 1 = byte offset 0 is the most significant lane |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_rdata | input | 32 | Word returned by memory one cycle after `mem_re` |
| mem_word_addr | output | 30 | Word address to memory |
| mem_re | output | 1 | Word read request |
| mem_we | output | 1 | Write request |
| mem_be | output | 4 | Per-lane write strobes |
| mem_wdata | output | 32 | Lane-replicated write word |
| fault | output | 1 | Misaligned or reserved-size request |
| load_valid | output | 1 | Load response present |
| load_data | output | 32 | Extended load result |

## Verification
In any one cycle, the response to the previous load leaves through `load_data` while a new request drives strobes and `fault`. The bench issues back-to-back requests to provoke every pairing: a store right after a load, a refused load right after an accepted one, and a change of `big_endian` between a load and its successor. A reference model judges both halves in every cycle. It holds its own shadow copy of memory, checks the request side a few nanoseconds after the inputs change, and checks the response of the previous request before new inputs are driven. Because of this, a response that picks up the next request's offset or numbering is reported.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_LOAD_RESP  = 2'd1,
        ST_FAULT_RESP = 2'd2
    } resp_state_e;

    typedef struct packed {
        logic [1:0] offset;
        acc_size_e  size;
        logic       sext;
        logic       big_end;
    } load_ctx_t;

endpackage

// File: rtl/lsu_misalign_detect.sv
module lsu_misalign_detect
    import lsu_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0] offset,
    input  acc_size_e        size,
    output logic             misaligned
);
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = offset[0];
            SZ_WORD: misaligned = |offset;
            default: misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_align_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic               enable,
    input  logic [OFF_W-1:0]   offset,
    input  acc_size_e          size,
    input  logic               big_end,
    input  logic [LANES*8-1:0] data_in,
    output logic [LANES-1:0]   strobe,
    output logic [LANES*8-1:0] data_out
);
    logic [OFF_W-1:0] byte_lane;
    logic [OFF_W-1:0] half_base;

    assign byte_lane = big_end ? ~offset : offset;
    assign half_base = {(big_end ? ~offset[OFF_W-1:1] : offset[OFF_W-1:1]), 1'b0};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_ID = OFF_W'(i);
        logic hit;
        always_comb begin
            unique case (size)
                SZ_BYTE: hit = (LANE_ID == byte_lane);
                SZ_HALF: hit = ({LANE_ID[OFF_W-1:1], 1'b0} == half_base);
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end
        assign strobe[i] = enable & hit;

        always_comb begin
            unique case (size)
                SZ_BYTE: data_out[8*i +: 8] = data_in[7:0];
                SZ_HALF: data_out[8*i +: 8] = data_in[8*(i%2) +: 8];
                default: data_out[8*i +: 8] = data_in[8*i +: 8];
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_align_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [LANES*8-1:0] word_in,
    input  load_ctx_t          ctx,
    output logic [LANES*8-1:0] result
);
    localparam int DATA_W = LANES * 8;

    logic [OFF_W-1:0] byte_lane;
    logic [OFF_W-1:0] half_base;
    logic [7:0]       sel_byte;
    logic [15:0]      sel_half;

    assign byte_lane = ctx.big_end ? ~ctx.offset : ctx.offset;
    assign half_base = {(ctx.big_end ? ~ctx.offset[OFF_W-1:1] : ctx.offset[OFF_W-1:1]), 1'b0};
    assign sel_byte  = word_in[{byte_lane, 3'b000} +: 8];
    assign sel_half  = word_in[{half_base, 3'b000} +: 16];

    always_comb begin
        unique case (ctx.size)
            SZ_BYTE: result = {{(DATA_W-8){ctx.sext & sel_byte[7]}}, sel_byte};
            SZ_HALF: result = {{(DATA_W-16){ctx.sext & sel_half[15]}}, sel_half};
            SZ_WORD: result = word_in;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int WADR_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic              big_endian,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [WADR_W-1:0] mem_word_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fault,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_data
);
    acc_size_e        size_e;
    logic [OFF_W-1:0] offset;
    logic             misaligned;
    resp_state_e      state_q, state_d;
    load_ctx_t        ctx_q;
    logic [DATA_W-1:0] extracted;

    assign size_e        = acc_size_e'(req_size);
    assign offset        = req_addr[OFF_W-1:0];
    assign mem_word_addr = req_addr[ADDR_W-1:OFF_W];

    lsu_misalign_detect #(.OFF_W(OFF_W)) u_detect (
        .offset     (offset),
        .size       (size_e),
        .misaligned (misaligned)
    );

    assign fault  = req_valid & misaligned;
    assign mem_re = req_valid & ~req_store & ~misaligned;
    assign mem_we = req_valid &  req_store & ~misaligned;

    lsu_store_lanes #(.LANES(LANES), .OFF_W(OFF_W)) u_store (
        .enable   (mem_we),
        .offset   (offset),
        .size     (size_e),
        .big_end  (big_endian),
        .data_in  (req_wdata),
        .strobe   (mem_be),
        .data_out (mem_wdata)
    );

    always_comb begin
        if (req_valid && !req_store)
            state_d = misaligned ? ST_FAULT_RESP : ST_LOAD_RESP;
        else
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (mem_re) begin
                ctx_q.offset  <= offset;
                ctx_q.size    <= size_e;
                ctx_q.sext    <= req_signed;
                ctx_q.big_end <= big_endian;
            end
        end
    end

    lsu_load_extract #(.LANES(LANES), .OFF_W(OFF_W)) u_extract (
        .word_in (mem_rdata),
        .ctx     (ctx_q),
        .result  (extracted)
    );

    always_comb begin
        unique case (state_q)
            ST_LOAD_RESP: begin
                load_valid = 1'b1;
                load_data  = extracted;
            end
            ST_FAULT_RESP: begin
                load_valid = 1'b1;
                load_data  = '0;
            end
            default: begin
                load_valid = 1'b0;
                load_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_store,
    input logic [1:0]  req_size,
    input logic        fault,
    input logic        mem_re,
    input logic        mem_we,
    input logic [3:0]  mem_be,
    input logic        load_valid,
    input logic [31:0] load_data
);
    assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (mem_be == 4'b0000 && !mem_we && !mem_re));

    assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'b00) |-> ($countones(mem_be) == 1));

    assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'b01 && !fault) |-> ($countones(mem_be) == 2));

    assert_word_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'b10 && !fault) |-> (mem_be == 4'b1111));

    assert_read_answered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> load_valid);

    assert_fault_load_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && fault) |=> (load_valid && load_data == 32'h0));

    assert_no_stray_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_store) |=> (!load_valid && load_data == 32'h0));
endmodule

bind lsu_align_unit lsu_align_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_size   (req_size),
    .fault      (fault),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .load_valid (load_valid),
    .load_data  (load_data)
);

// File: tb/lsu_align_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_align_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store, req_signed, big_endian;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata, mem_rdata;
    logic [29:0] mem_word_addr;
    logic        mem_re, mem_we, fault, load_valid;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, load_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] mem     [16];
    logic [31:0] ref_mem [16];

    logic        pend_valid = 1'b0;
    logic [31:0] pend_data  = '0;
    string       pend_tag   = "R11";

    always #10 clk = ~clk;

    lsu_align_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_signed(req_signed), .big_endian(big_endian),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
        .mem_word_addr(mem_word_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .fault(fault),
        .load_valid(load_valid), .load_data(load_data)
    );

    always @(posedge clk) begin
        if (mem_we)
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[mem_word_addr[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
        if (mem_re) mem_rdata <= mem[mem_word_addr[3:0]];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lane_of(input logic [1:0] off, input logic big);
        return big ? 3 - int'(off) : int'(off);
    endfunction

    function automatic logic [31:0] exp_load(input logic [31:0] w, input logic [1:0] off,
                                             input logic [1:0] sz, input logic sg, input logic big);
        logic [7:0]  b;
        logic [15:0] h;
        b = 8'(w >> (8 * lane_of(off, big)));
        h = (big ? (off == 2'd0) : (off == 2'd2)) ? w[31:16] : w[15:0];
        case (sz)
            2'b00:   return sg ? {{24{b[7]}}, b} : {24'h0, b};
            2'b01:   return sg ? {{16{h[15]}}, h} : {16'h0, h};
            default: return w;
        endcase
    endfunction

    task automatic step(input logic v, input logic [31:0] a, input logic [1:0] sz,
                        input logic sg, input logic st, input logic [31:0] wd, input logic big);
        logic        f;
        logic [3:0]  ebe;
        logic [31:0] ewd;
        string       rq;
        @(negedge clk);
        chk({pend_tag, " load_valid"}, {31'h0, load_valid}, {31'h0, pend_valid});
        chk({pend_tag, " load_data"}, load_data, pend_data);
        req_valid = v; req_addr = a; req_size = sz; req_signed = sg;
        req_store = st; req_wdata = wd; big_endian = big;
        #2;
        f  = v && (sz == 2'b11 || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00));
        rq = (sz == 2'b00) ? "R2" : (sz == 2'b01) ? "R3" : "R4";
        chk("R5 fault", {31'h0, fault}, {31'h0, f});
        if (v) chk("R1 word addr", {2'b00, mem_word_addr}, {2'b00, a[31:2]});
        ebe = 4'b0000;
        ewd = wd;
        if (v && st && !f) begin
            case (sz)
                2'b00: begin ebe = 4'b0001 << lane_of(a[1:0], big); ewd = {4{wd[7:0]}}; end
                2'b01: begin ebe = ((a[1] ^ big) ? 4'b1100 : 4'b0011); ewd = {2{wd[15:0]}}; end
                default: ebe = 4'b1111;
            endcase
            chk({rq, " wdata"}, mem_wdata, ewd);
        end
        chk(f ? "R5 strobes" : {rq, " strobes"}, {28'h0, mem_be}, {28'h0, ebe});
        chk("R5 mem_we", {31'h0, mem_we}, {31'h0, v && st && !f});
        chk("R6 mem_re", {31'h0, mem_re}, {31'h0, v && !st && !f});
        pend_valid = v && !st;
        if (!(v && !st)) begin pend_data = '0; pend_tag = "R11"; end
        else if (f) begin pend_data = '0; pend_tag = "R10"; end
        else begin
            pend_data = exp_load(ref_mem[a[5:2]], a[1:0], sz, sg, big);
            pend_tag  = (sz == 2'b10) ? "R9" : (sz == 2'b01) ? "R8" : (sg ? "R7" : "R6");
        end
        if (v && st && !f)
            for (int k = 0; k < 4; k++)
                if (ebe[k]) ref_mem[a[5:2]][8*k +: 8] = ewd[8*k +: 8];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]     = (32'h9E37_79B9 * (i + 1)) ^ 32'h8070_F00F;
            ref_mem[i] = (32'h9E37_79B9 * (i + 1)) ^ 32'h8070_F00F;
        end
        mem_rdata = '0;
        rst_n = 1'b0;
        req_valid = 0; req_store = 0; req_size = 0; req_signed = 0;
        big_endian = 0; req_addr = 0; req_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset load_valid", {31'h0, load_valid}, 32'h0);
        rst_n = 1'b1;
        // R4 / R9 word store then loads in both numberings
        step(1, 32'h0000_0000, 2'b10, 0, 1, 32'h8A7B_6C5D, 0);
        step(1, 32'h0000_0000, 2'b10, 0, 0, 32'h0, 0);
        step(1, 32'h0000_0000, 2'b10, 0, 0, 32'h0, 1);
        // R6 / R7 byte loads, every offset, both numberings, both signs
        for (int o = 0; o < 4; o++) begin
            step(1, 32'(o), 2'b00, 0, 0, 32'h0, 0);
            step(1, 32'(o), 2'b00, 1, 0, 32'h0, 0);
            step(1, 32'(o), 2'b00, 1, 0, 32'h0, 1);
            step(1, 32'(o), 2'b00, 0, 0, 32'h0, 1);
        end
        // R2 byte stores then readback
        step(1, 32'h0000_0005, 2'b00, 0, 1, 32'h0000_00F1, 0);
        step(1, 32'h0000_0006, 2'b00, 0, 1, 32'h0000_0082, 1);
        step(1, 32'h0000_0004, 2'b10, 0, 0, 32'h0, 0);
        // R3 / R8 halfword stores and loads
        step(1, 32'h0000_0008, 2'b01, 0, 1, 32'h0000_F00D, 0);
        step(1, 32'h0000_000A, 2'b01, 0, 1, 32'h0000_1234, 1);
        step(1, 32'h0000_0008, 2'b01, 1, 0, 32'h0, 0);
        step(1, 32'h0000_0008, 2'b01, 1, 0, 32'h0, 1);
        step(1, 32'h0000_000A, 2'b01, 0, 0, 32'h0, 1);
        step(1, 32'h0000_000A, 2'b01, 1, 0, 32'h0, 0);
        // R5 / R10 faults, back-to-back with good loads
        step(1, 32'h0000_0009, 2'b01, 1, 0, 32'h0, 0);
        step(1, 32'h0000_0006, 2'b10, 0, 1, 32'hFFFF_FFFF, 0);
        step(1, 32'h0000_0004, 2'b11, 0, 0, 32'h0, 1);
        step(1, 32'h0000_0004, 2'b10, 0, 0, 32'h0, 0);
        step(1, 32'h0000_0007, 2'b10, 1, 0, 32'h0, 1);
        // R11 idle and store cycles give no response
        step(0, 32'h0000_0000, 2'b10, 0, 0, 32'h0, 0);
        step(1, 32'h0000_0010, 2'b10, 0, 1, 32'h0BAD_CAFE, 0);
        step(0, 32'h0000_0000, 2'b00, 0, 0, 32'h0, 0);
        // mixed traffic, R1 with high address bits
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], $urandom, 2'(r[3:2]), r[4], r[5], $urandom, r[6]);
        end
        step(0, 32'h0, 2'b00, 0, 0, 32'h0, 0);
        step(0, 32'h0, 2'b00, 0, 0, 32'h0, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule